// File: doc/BRIEF.md
# Long subroutine call sequencer

This block drives the bus, one cycle at a time, for a long subroutine call on a processor bus with 8-bit data and 24-bit addresses. An external decoder asserts `go` while the block sits idle. The block treats that cycle as the opcode fetch. If the byte read back is the call opcode 0x22, the block runs seven more bus cycles. It reads a three-byte target (low, high, bank), pushes the return bank and return address onto a stack in bank 0, and then loads the new program bank and program counter.

The program counter, program bank and stack pointer are visible as outputs. They can be preset through a load strobe while the block is idle. Memory answers each read in the same cycle, on `din`, and the block samples it at the rising edge that ends the cycle. The bus has no ready signal and no back-pressure: every cycle completes, and a slow memory must be handled outside the block. Program addresses are formed as bank:PC. Stack addresses are formed as 0x00:SP.

Top module: `lcall_seq`

## Requirements
- R1: After reset, pc = 0x0000, pbr = 0x00, sp = 0x01FF (parameter), done = 0, and the block is idle.
- R2: With `go` high in idle, the bus reads pbr:pc with both vpa and vda high. This is bus cycle 0. The call sequence starts only if `din` equals 0x22 in that cycle.
- R3: Bus cycles 1 and 2 read the low and high target bytes from pbr:pc+1 and pbr:pc+2, with vpa = 1, vda = 0 and rw_n = 1. The pc advances after each of these reads.
- R4: Bus cycle 3 writes the current pbr to 0x00:sp with vda = 1, vpa = 0 and rw_n = 0. The sp does not change.
- R5: Bus cycle 4 is a throwaway read of 0x00:sp with rw_n = 1 and vpa = vda = 0. The sp decrements after it.
- R6: Bus cycle 5 reads the bank byte from pbr:pc with vpa only. The pc is not advanced, and pbr takes the byte at the end of that cycle.
- R7: Bus cycles 6 and 7 write the high byte and then the low byte of pc to 0x00:sp, and the sp decrements after each write. The pushed value is the address of the bank byte, which is the start pc + 3. The pc holds during bus cycle 6.
- R8: `done` is high for exactly bus cycle 7. After it, pc = {high, low} target, pbr = the bank byte, sp = start sp − 3, and the idle bus shows the new pbr:pc.
- R9: Every write goes to bank 0 with vda = 1 and vpa = 0. The pc and sp wrap modulo 2^16.
- R10: A byte other than 0x22 in bus cycle 0 is ignored. The block stays idle, nothing is written, and pc, pbr and sp are unchanged.
- R11: With `ld_en` high in idle, pc, pbr and sp take `ld_pc`, `ld_pbr` and `ld_sp`, and a `go` in the same cycle is ignored. `ld_en` has no effect while a sequence runs.
- R12: In idle with `go` low, rw_n = 1, vpa = 0 and vda = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Opcode fetch cycle is happening now (honoured only in idle) |
| din | input | 8 | Read data for the current bus cycle |
| ld_en | input | 1 | Preset pc, pbr and sp (idle only) |
| ld_pc | input | 16 | Preset value for pc |
| ld_pbr | input | 8 | Preset value for pbr |
| ld_sp | input | 16 | Preset value for sp |
| addr | output | 24 | Bus address |
| dout | output | 8 | Write data |
| rw_n | output | 1 | 1 = read, 0 = write |
| vpa | output | 1 | Valid program address strobe |
| vda | output | 1 | Valid data address strobe |
| done | output | 1 | Final cycle of the call |
| pc | output | 16 | Program counter |
| pbr | output | 8 | Program bank |
| sp | output | 16 | Stack pointer |

## Verification
On every cycle, the assertions check four things. Writes stay in bank 0 and carry only the data strobe. `done` never lasts two cycles. The sp drops by one across the final cycle. The pc holds through the first two writes of a sequence. The bench's scenarios are the only place that shows the exact ordering of the eight cycles and the byte values pushed. The same holds for the returned target, the wrap of pc and sp at 0xFFFF/0x0000, the rejection of a wrong opcode, and the rule that a preset during a sequence has no effect.

// File: rtl/lcall_pkg.sv
package lcall_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OPLO  = 3'd1,
    ST_OPHI  = 3'd2,
    ST_PUSHB = 3'd3,
    ST_DUMMY = 3'd4,
    ST_BANK  = 3'd5,
    ST_PUSHH = 3'd6,
    ST_PUSHL = 3'd7
  } lc_state_t;
endpackage

// File: rtl/lcall_fsm.sv
module lcall_fsm
  import lcall_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] OPCODE = 'h22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] din,
  output lc_state_t         state,
  output logic              accept,
  output logic              done
);
  lc_state_t nxt;

  // a preset in the same cycle wins over the opcode fetch
  assign accept = (state == ST_IDLE) && go && !ld_en && (din == OPCODE);
  assign done   = (state == ST_PUSHL);

  always_comb begin
    case (state)
      ST_IDLE:  nxt = accept ? ST_OPLO : ST_IDLE;
      ST_OPLO:  nxt = ST_OPHI;
      ST_OPHI:  nxt = ST_PUSHB;
      ST_PUSHB: nxt = ST_DUMMY;
      ST_DUMMY: nxt = ST_BANK;
      ST_BANK:  nxt = ST_PUSHH;
      ST_PUSHH: nxt = ST_PUSHL;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/lcall_regs.sv
module lcall_regs
  import lcall_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [2*DATA_W-1:0] SP_RESET = 'h01FF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  lc_state_t           state,
  input  logic                accept,
  input  logic                ld_en,
  input  logic [2*DATA_W-1:0] ld_pc,
  input  logic [DATA_W-1:0]   ld_pbr,
  input  logic [2*DATA_W-1:0] ld_sp,
  input  logic [DATA_W-1:0]   din,
  output logic [2*DATA_W-1:0] pc,
  output logic [DATA_W-1:0]   pbr,
  output logic [2*DATA_W-1:0] sp
);
  localparam int PC_W = 2 * DATA_W;

  logic [DATA_W-1:0] tgt_lo, tgt_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      pbr    <= '0;
      sp     <= SP_RESET;
      tgt_lo <= '0;
      tgt_hi <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ld_en) begin
            pc  <= ld_pc;
            pbr <= ld_pbr;
            sp  <= ld_sp;
          end else if (accept) begin
            pc <= pc + 1'b1;
          end
        end
        ST_OPLO: begin
          tgt_lo <= din;
          pc     <= pc + 1'b1;
        end
        ST_OPHI: begin
          tgt_hi <= din;
          pc     <= pc + 1'b1;
        end
        ST_DUMMY: sp  <= sp - 1'b1;
        ST_BANK:  pbr <= din;      // pc stays on the bank byte
        ST_PUSHH: sp  <= sp - 1'b1;
        ST_PUSHL: begin
          sp <= sp - 1'b1;
          pc <= PC_W'({tgt_hi, tgt_lo});
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lcall_bus.sv
module lcall_bus
  import lcall_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  lc_state_t           state,
  input  logic                go,
  input  logic [2*DATA_W-1:0] pc,
  input  logic [DATA_W-1:0]   pbr,
  input  logic [2*DATA_W-1:0] sp,
  output logic [3*DATA_W-1:0] addr,
  output logic [DATA_W-1:0]   dout,
  output logic                rw_n,
  output logic                vpa,
  output logic                vda
);
  localparam int PC_W   = 2 * DATA_W;
  localparam int ADDR_W = 3 * DATA_W;

  logic [ADDR_W-1:0] prog_addr, stk_addr;

  assign prog_addr = {pbr, pc};
  assign stk_addr  = {{DATA_W{1'b0}}, sp};

  always_comb begin
    addr = prog_addr;
    dout = '0;
    rw_n = 1'b1;
    vpa  = 1'b0;
    vda  = 1'b0;
    case (state)
      ST_IDLE: begin
        vpa = go;
        vda = go;
      end
      ST_OPLO, ST_OPHI, ST_BANK: vpa = 1'b1;
      ST_PUSHB: begin
        addr = stk_addr;
        rw_n = 1'b0;
        vda  = 1'b1;
        dout = pbr;
      end
      ST_DUMMY: addr = stk_addr;
      ST_PUSHH: begin
        addr = stk_addr;
        rw_n = 1'b0;
        vda  = 1'b1;
        dout = pc[PC_W-1:DATA_W];
      end
      ST_PUSHL: begin
        addr = stk_addr;
        rw_n = 1'b0;
        vda  = 1'b1;
        dout = pc[DATA_W-1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lcall_seq.sv
module lcall_seq
  import lcall_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] OPCODE = 'h22,
  parameter logic [2*DATA_W-1:0] SP_RESET = 'h01FF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [DATA_W-1:0]   din,
  input  logic                ld_en,
  input  logic [2*DATA_W-1:0] ld_pc,
  input  logic [DATA_W-1:0]   ld_pbr,
  input  logic [2*DATA_W-1:0] ld_sp,
  output logic [3*DATA_W-1:0] addr,
  output logic [DATA_W-1:0]   dout,
  output logic                rw_n,
  output logic                vpa,
  output logic                vda,
  output logic                done,
  output logic [2*DATA_W-1:0] pc,
  output logic [DATA_W-1:0]   pbr,
  output logic [2*DATA_W-1:0] sp
);
  lc_state_t state;
  logic      accept;

  lcall_fsm #(.DATA_W(DATA_W), .OPCODE(OPCODE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .ld_en(ld_en), .din(din),
    .state(state), .accept(accept), .done(done)
  );

  lcall_regs #(.DATA_W(DATA_W), .SP_RESET(SP_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .state(state), .accept(accept),
    .ld_en(ld_en), .ld_pc(ld_pc), .ld_pbr(ld_pbr), .ld_sp(ld_sp),
    .din(din), .pc(pc), .pbr(pbr), .sp(sp)
  );

  lcall_bus #(.DATA_W(DATA_W)) u_bus (
    .state(state), .go(go), .pc(pc), .pbr(pbr), .sp(sp),
    .addr(addr), .dout(dout), .rw_n(rw_n), .vpa(vpa), .vda(vda)
  );
endmodule

// File: rtl/lcall_seq_chk.sv
module lcall_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [3*DATA_W-1:0] addr,
  input logic                rw_n,
  input logic                vpa,
  input logic                vda,
  input logic                done,
  input logic [2*DATA_W-1:0] pc,
  input logic [2*DATA_W-1:0] sp
);
  localparam int PC_W   = 2 * DATA_W;
  localparam int ADDR_W = 3 * DATA_W;

  logic [PC_W-1:0] sp_less;
  assign sp_less = sp - 1'b1;

  AST_STACK_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_n |-> (addr[ADDR_W-1:PC_W] == '0)); // R9

  AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_n |-> (vda && !vpa)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_SP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (sp == $past(sp_less))); // R7

  AST_PC_HOLD_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw_n && !done) |=> $stable(pc)); // R7
endmodule

bind lcall_seq lcall_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rw_n(rw_n), .vpa(vpa),
  .vda(vda), .done(done), .pc(pc), .sp(sp)
);

// File: tb/lcall_seq_test.sv
module lcall_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [7:0]  din;
  logic        ld_en = 1'b0;
  logic [15:0] ld_pc = '0;
  logic [7:0]  ld_pbr = '0;
  logic [15:0] ld_sp = '0;
  logic [23:0] addr;
  logic [7:0]  dout;
  logic        rw_n, vpa, vda, done;
  logic [15:0] pc, sp;
  logic [7:0]  pbr;

  int nchk = 0;
  int nerr = 0;

  // bench model of program memory and expected registers
  logic [7:0]  code [4];
  logic [7:0]  cbank = '0;
  logic [15:0] cpc = '0;
  logic [15:0] e_pc = '0;
  logic [7:0]  e_pbr = '0;
  logic [15:0] e_sp = 16'h01FF;

  typedef struct {
    logic        rw;
    logic [23:0] a;
    logic [7:0]  d;
    logic        cd;
    logic        p;
    logic        v;
    logic        dn;
    string       tag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  lcall_seq uut (
    .clk(clk), .rst_n(rst_n), .go(go), .din(din), .ld_en(ld_en),
    .ld_pc(ld_pc), .ld_pbr(ld_pbr), .ld_sp(ld_sp), .addr(addr),
    .dout(dout), .rw_n(rw_n), .vpa(vpa), .vda(vda), .done(done),
    .pc(pc), .pbr(pbr), .sp(sp)
  );

  function automatic logic [7:0] mem_rd(input logic [23:0] a);
    for (int i = 0; i < 4; i++)
      if (a == {cbank, cpc + 16'(i)}) return code[i];
    return 8'hEA;
  endfunction

  always_comb din = mem_rd(addr);

  // monitor: one expected bus item per cycle while the queue holds any
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      nchk++;
      if (rw_n !== e.rw || addr !== e.a || vpa !== e.p || vda !== e.v ||
          done !== e.dn || (e.cd && dout !== e.d)) begin
        nerr++;
        $display("FAIL %s: actual rw=%b addr=%h dout=%h vpa=%b vda=%b done=%b expected rw=%b addr=%h dout=%h vpa=%b vda=%b done=%b",
                 e.tag, rw_n, addr, dout, vpa, vda, done, e.rw, e.a, e.d, e.p, e.v, e.dn);
      end
    end
  end

  task automatic put(input logic rw, input logic [23:0] a, input logic [7:0] d,
                     input logic cd, input logic p, input logic v,
                     input logic dn, input string t);
    item_t it;
    it.rw = rw; it.a = a; it.d = d; it.cd = cd;
    it.p = p; it.v = v; it.dn = dn; it.tag = t;
    q.push_back(it);
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic preset(input logic [15:0] p, input logic [7:0] b, input logic [15:0] s);
    @(posedge clk); #1;
    ld_en = 1'b1; ld_pc = p; ld_pbr = b; ld_sp = s;
    @(posedge clk); #1;
    ld_en = 1'b0;
    e_pc = p; e_pbr = b; e_sp = s;
    chk("R11 preset pc", {16'h0, pc}, {16'h0, p});
    chk("R11 preset pbr", {24'h0, pbr}, {24'h0, b});
    chk("R11 preset sp", {16'h0, sp}, {16'h0, s});
  endtask

  // driver: queue the eight expected bus cycles, then launch the call
  task automatic run_call(input logic [7:0] lo, input logic [7:0] hi,
                          input logic [7:0] bk, input bit mid_ld);
    logic [15:0] ret;
    ret = e_pc + 16'd3;
    @(posedge clk); #1;
    cbank = e_pbr; cpc = e_pc;
    code[0] = 8'h22; code[1] = lo; code[2] = hi; code[3] = bk;
    put(1, {e_pbr, e_pc},          8'h0,      0, 1, 1, 0, "R2 opcode fetch");
    put(1, {e_pbr, e_pc + 16'd1},  8'h0,      0, 1, 0, 0, "R3 low operand");
    put(1, {e_pbr, e_pc + 16'd2},  8'h0,      0, 1, 0, 0, "R3 high operand");
    put(0, {8'h00, e_sp},          e_pbr,     1, 0, 1, 0, "R4 bank push");
    put(1, {8'h00, e_sp},          8'h0,      0, 0, 0, 0, "R5 dummy read");
    put(1, {e_pbr, ret},           8'h0,      0, 1, 0, 0, "R6 bank operand");
    put(0, {8'h00, e_sp - 16'd1},  ret[15:8], 1, 0, 1, 0, "R7 high push");
    put(0, {8'h00, e_sp - 16'd2},  ret[7:0],  1, 0, 1, 1, "R8 low push");
    go = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(posedge clk); #1;
      go = 1'b0;
      ld_en = (mid_ld && c == 2);
      if (ld_en) begin
        ld_pc = 16'hDEAD; ld_pbr = 8'hBE; ld_sp = 16'h7777;
      end
    end
    e_pc = {hi, lo}; e_pbr = bk; e_sp = e_sp - 16'd3;
    chk("R8 pc after", {16'h0, pc}, {16'h0, e_pc});
    chk("R8 pbr after", {24'h0, pbr}, {24'h0, e_pbr});
    chk("R8 sp after", {16'h0, sp}, {16'h0, e_sp});
    chk("R8 idle addr", {8'h0, addr}, {8'h0, e_pbr, e_pc});
    chk("R8 done low", {31'h0, done}, 32'h0);
    if (mid_ld) chk("R11 no load mid-call", {16'h0, pc}, {16'h0, e_pc});
  endtask

  initial begin
    #2000000;
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    code[0] = 8'h22; code[1] = 8'h0; code[2] = 8'h0; code[3] = 8'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 pc", {16'h0, pc}, 32'h0);
    chk("R1 pbr", {24'h0, pbr}, 32'h0);
    chk("R1 sp", {16'h0, sp}, 32'h01FF);
    chk("R1 done", {31'h0, done}, 32'h0);
    chk("R12 idle strobes", {29'h0, rw_n, vpa, vda}, 32'h4);

    // call $123456 from 00:0000, pushes 00,00,03
    run_call(8'h56, 8'h34, 8'h12, 0);
    // second call from the new location 12:3456, pushes 12,34,59
    run_call(8'h00, 8'h80, 8'h00, 0);
    // operands wrap the pc within the bank; return address wraps to 0000
    preset(16'hFFFD, 8'h7E, 16'h01FC);
    run_call(8'h11, 8'h22, 8'h33, 0);
    // sp wraps through 0000; a preset during the call is ignored
    preset(16'h1000, 8'h40, 16'h0001);
    run_call(8'hAA, 8'hBB, 8'h05, 1);

    // R10: wrong opcode is ignored
    @(posedge clk); #1;
    cbank = e_pbr; cpc = e_pc; code[0] = 8'hA9;
    go = 1'b1;
    @(negedge clk);
    chk("R10 fetch strobes", {29'h0, rw_n, vpa, vda}, 32'h7);
    @(posedge clk); #1;
    go = 1'b0;
    @(negedge clk);
    chk("R10 pc unchanged", {16'h0, pc}, {16'h0, e_pc});
    chk("R10 sp unchanged", {16'h0, sp}, {16'h0, e_sp});
    chk("R10 still idle", {29'h0, rw_n, vpa, vda}, 32'h4);
    chk("R10 no done", {31'h0, done}, 32'h0);

    // R11: preset beats a valid opcode fetch in the same cycle
    @(posedge clk); #1;
    code[0] = 8'h22;
    go = 1'b1; ld_en = 1'b1; ld_pc = 16'h2000; ld_pbr = 8'h01; ld_sp = 16'h0300;
    @(posedge clk); #1;
    go = 1'b0; ld_en = 1'b0;
    e_pc = 16'h2000; e_pbr = 8'h01; e_sp = 16'h0300;
    @(negedge clk);
    chk("R11 go ignored", {29'h0, rw_n, vpa, vda}, 32'h4);
    chk("R11 pc loaded", {16'h0, pc}, 32'h2000);
    chk("R11 sp loaded", {16'h0, sp}, 32'h0300);

    run_call(8'h01, 8'h02, 8'h03, 0);
    @(posedge clk); #1;
    chk("R12 idle after call", {29'h0, rw_n, vpa, vda}, 32'h4);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule